// File: doc/BRIEF.md
# Interrupt Mask and Serial Bit Unit

This block holds the interrupt enable, mask and pending state of a small 8-bit processor. It serves three maskable request lines of fixed priority: a top line that is caught on a rising edge, and two lower lines that are level-sensitive. It also holds one serial output bit and reports one serial input bit. The core drives four operations into it: enable interrupts, disable interrupts, a mask write that carries a packed 8-bit operand, and a status read that returns a packed 8-bit word. The core also pulses an accept input when it takes an interrupt.

A mask write can do three things at once. It can update the serial output bit when its serial-enable bit is set. It can clear the captured top-line edge. It can load all three masks when its mask-load bit is set. The status word is combinational and always valid, so a status read is simply a sample of `status_o`. Requests to the core are one-hot, and at most the winning line is raised.

Top module: `irq_mask_unit`

## Requirements
- R1: While rst_ni is low, the enable flag is 0, all three masks are 1, sod_o is 0, the top-line capture is clear and req_o is 0.
- R2: A cycle with ei_i sets the enable flag (status bit 3) from the next cycle on. A cycle with di_i clears it. When both are high in the same cycle, di_i wins.
- R3: A cycle with irq_ack_i clears the enable flag from the next cycle on, even when ei_i is high in that same cycle.
- R4: On a mask write with operand bit 6 = 1, sod_o takes operand bit 7. With bit 6 = 0, sod_o keeps its value.
- R5: On a mask write with operand bit 3 = 1, operand bits 2, 1 and 0 load the masks of the top, middle and low lines. With bit 3 = 0, the masks keep their values. A mask of 1 blocks its line.
- R6: A rising edge on irq_line_i[2], the top line, sets its pending flag. The flag stays set after the line falls.
- R7: A mask write with operand bit 4 = 1 clears the top pending flag. A rising edge in that same cycle wins, and the flag stays set.
- R8: irq_ack_i clears the top pending flag when req_o[2] is high in that cycle.
- R9: The middle and low lines (irq_line_i[1], irq_line_i[0]) are pending exactly while they are high, in the same cycle.
- R10: req_o[k] is 1 only when the enable flag is 1, line k is unmasked, line k is pending and no higher line meets all three. Priority runs from bit 2 down to bit 0.
- R11: status_o packs, from bit 7 down: sid_i, the top, middle and low pending flags, the enable flag, and the top, middle and low masks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ei_i | input | 1 | Enable-interrupts operation |
| di_i | input | 1 | Disable-interrupts operation |
| mask_wr_i | input | 1 | Mask write operation |
| mask_word_i | input | 8 | Packed mask write operand |
| irq_ack_i | input | 1 | Interrupt accepted by the core |
| irq_line_i | input | 3 | Request lines: bit 2 top (edge), bits 1..0 level |
| sid_i | input | 1 | Serial input bit |
| status_o | output | 8 | Packed status word |
| req_o | output | 3 | One-hot request to the core |
| sod_o | output | 1 | Serial output bit |

## Verification
The assertions check several properties on every cycle. req_o is never more than one-hot, and it is never raised while the enable flag is clear. An accept or a disable always leaves the enable flag clear. A rising top-line edge always shows up as pending in the next cycle. Masks and the serial bit move only when their enable bits in the operand allow it. Other behaviours depend on a particular sequence of events, and only the bench scenarios show them. These are the priority hand-over as lines come and go, the top flag surviving the fall of its line, the edge-versus-clear race, and an accept that clears the top flag only when that line was the one granted.

// File: rtl/irqm_pkg.sv
package irqm_pkg;
  localparam int unsigned NUM_LINES = 3;
  localparam int unsigned WORD_W    = 8;
  localparam int unsigned TOP_LINE  = NUM_LINES - 1;
  // operand fields of a mask write
  localparam int unsigned OP_SOD_BIT   = 7;
  localparam int unsigned OP_SDE_BIT   = 6;
  localparam int unsigned OP_CLR_BIT   = 4;
  localparam int unsigned OP_MLOAD_BIT = 3;
endpackage

// File: rtl/irqm_edge_latch.sv
module irqm_edge_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  input  logic clr_i,
  output logic pend_o
);
  logic prev_q;
  logic rise;

  assign rise = line_i & ~prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      pend_o <= 1'b0;
    end else begin
      prev_q <= line_i;
      pend_o <= (pend_o & ~clr_i) | rise; // new edge beats clear
    end
  end
endmodule

// File: rtl/irqm_prio_sel.sv
module irqm_prio_sel #(
  parameter int unsigned N = 3
) (
  input  logic [N-1:0] cand_i,
  output logic [N-1:0] grant_o
);
  for (genvar i = 0; i < N; i++) begin : g_sel
    if (i == N - 1) begin : g_top
      assign grant_o[i] = cand_i[i];
    end else begin : g_low
      assign grant_o[i] = cand_i[i] & ~(|cand_i[N-1:i+1]);
    end
  end
endmodule

// File: rtl/irq_mask_unit.sv
module irq_mask_unit
  import irqm_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ei_i,
  input  logic                 di_i,
  input  logic                 mask_wr_i,
  input  logic [WORD_W-1:0]    mask_word_i,
  input  logic                 irq_ack_i,
  input  logic [NUM_LINES-1:0] irq_line_i,
  input  logic                 sid_i,
  output logic [WORD_W-1:0]    status_o,
  output logic [NUM_LINES-1:0] req_o,
  output logic                 sod_o
);
  logic                 ie_q;
  logic [NUM_LINES-1:0] mask_q;
  logic                 sod_q;
  logic                 top_pend;
  logic                 top_clr;
  logic [NUM_LINES-1:0] pend;
  logic [NUM_LINES-1:0] cand;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ie_q <= 1'b0;
    end else if (di_i || irq_ack_i) begin
      ie_q <= 1'b0;
    end else if (ei_i) begin
      ie_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '1;
      sod_q  <= 1'b0;
    end else if (mask_wr_i) begin
      if (mask_word_i[OP_MLOAD_BIT]) mask_q <= mask_word_i[NUM_LINES-1:0];
      if (mask_word_i[OP_SDE_BIT])   sod_q  <= mask_word_i[OP_SOD_BIT];
    end
  end

  assign top_clr = (mask_wr_i & mask_word_i[OP_CLR_BIT]) | (irq_ack_i & req_o[TOP_LINE]);

  irqm_edge_latch i_top_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .line_i (irq_line_i[TOP_LINE]),
    .clr_i  (top_clr),
    .pend_o (top_pend)
  );

  assign pend = {top_pend, irq_line_i[TOP_LINE-1:0]};
  assign cand = pend & ~mask_q & {NUM_LINES{ie_q}};

  irqm_prio_sel #(.N(NUM_LINES)) i_prio (
    .cand_i  (cand),
    .grant_o (req_o)
  );

  assign status_o = {sid_i, pend, ie_q, mask_q};
  assign sod_o    = sod_q;
endmodule

// File: rtl/irq_mask_unit_chk.sv
module irq_mask_unit_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ei_i,
  input logic       di_i,
  input logic       mask_wr_i,
  input logic [7:0] mask_word_i,
  input logic       irq_ack_i,
  input logic [2:0] irq_line_i,
  input logic [7:0] status_o,
  input logic [2:0] req_o,
  input logic       sod_o
);
  // R10
  req_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot0(req_o));
  // R10
  req_needs_ie_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) (|req_o) |-> status_o[3]);
  // R3
  ack_clears_ie_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) irq_ack_i |=> !status_o[3]);
  // R2
  di_clears_ie_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) di_i |=> !status_o[3]);
  // R2
  ei_sets_ie_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ei_i && !di_i && !irq_ack_i) |=> status_o[3]);
  // R6
  top_edge_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_line_i[2]) |=> status_o[6]);
  // R4
  sod_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_wr_i && mask_word_i[6]) |=> (sod_o == $past(mask_word_i[7])));
  // R5
  mask_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mask_wr_i && mask_word_i[3]) |=> $stable(status_o[2:0]));
endmodule

bind irq_mask_unit irq_mask_unit_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ei_i        (ei_i),
  .di_i        (di_i),
  .mask_wr_i   (mask_wr_i),
  .mask_word_i (mask_word_i),
  .irq_ack_i   (irq_ack_i),
  .irq_line_i  (irq_line_i),
  .status_o    (status_o),
  .req_o       (req_o),
  .sod_o       (sod_o)
);

// File: tb/test_irq_mask_unit.sv
module test_irq_mask_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 21;

  // ctl = {ei, di, mask_wr, ack}
  typedef struct packed {
    logic [3:0] rq;
    logic [3:0] ctl;
    logic [7:0] word;
    logic [2:0] lines;
    logic       sid;
    logic [7:0] st;
    logic [2:0] req;
    logic       sod;
  } vec_t;

  localparam vec_t TBL [NV] = '{
    '{4'd11, 4'b0000, 8'h00, 3'b000, 1'b1, 8'h87, 3'b000, 1'b0}, // R11 idle after reset
    '{4'd2,  4'b1000, 8'h00, 3'b000, 1'b0, 8'h0F, 3'b000, 1'b0}, // R2 enable
    '{4'd4,  4'b0010, 8'hC8, 3'b000, 1'b0, 8'h08, 3'b000, 1'b1}, // R4 sod=1, masks open
    '{4'd9,  4'b0000, 8'h00, 3'b001, 1'b0, 8'h18, 3'b001, 1'b1}, // R9 low line level
    '{4'd10, 4'b0000, 8'h00, 3'b011, 1'b0, 8'h38, 3'b010, 1'b1}, // R10 middle wins
    '{4'd6,  4'b0000, 8'h00, 3'b111, 1'b0, 8'h78, 3'b100, 1'b1}, // R6 top edge
    '{4'd6,  4'b0000, 8'h00, 3'b011, 1'b0, 8'h78, 3'b100, 1'b1}, // R6 held after fall
    '{4'd8,  4'b0001, 8'h00, 3'b011, 1'b0, 8'h30, 3'b000, 1'b1}, // R8 ack clears top, R3 ie
    '{4'd2,  4'b1000, 8'h00, 3'b011, 1'b0, 8'h38, 3'b010, 1'b1}, // R2 re-enable
    '{4'd5,  4'b0010, 8'h0A, 3'b011, 1'b0, 8'h3A, 3'b001, 1'b1}, // R5 mask middle, sod kept
    '{4'd4,  4'b0010, 8'h40, 3'b011, 1'b0, 8'h3A, 3'b001, 1'b0}, // R4 sod=0, masks kept
    '{4'd6,  4'b0000, 8'h00, 3'b111, 1'b0, 8'h7A, 3'b100, 1'b0}, // R6 second edge
    '{4'd7,  4'b0010, 8'h10, 3'b111, 1'b0, 8'h3A, 3'b001, 1'b0}, // R7 clear top
    '{4'd2,  4'b0100, 8'h00, 3'b011, 1'b0, 8'h32, 3'b000, 1'b0}, // R2 disable
    '{4'd2,  4'b1100, 8'h00, 3'b011, 1'b0, 8'h32, 3'b000, 1'b0}, // R2 di wins
    '{4'd9,  4'b0000, 8'h00, 3'b000, 1'b0, 8'h02, 3'b000, 1'b0}, // R9 levels drop
    '{4'd2,  4'b1000, 8'h00, 3'b000, 1'b0, 8'h0A, 3'b000, 1'b0}, // R2 enable
    '{4'd10, 4'b0010, 8'h0F, 3'b100, 1'b0, 8'h4F, 3'b000, 1'b0}, // R10 all masked
    '{4'd7,  4'b0010, 8'h18, 3'b000, 1'b0, 8'h08, 3'b000, 1'b0}, // R7 clear + open masks
    '{4'd7,  4'b0010, 8'h10, 3'b100, 1'b0, 8'h48, 3'b100, 1'b0}, // R7 edge beats clear
    '{4'd3,  4'b1001, 8'h00, 3'b100, 1'b0, 8'h00, 3'b000, 1'b0}  // R3 ack beats ei, R8
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ei = 1'b0, di = 1'b0, mask_wr = 1'b0, ack = 1'b0, sid = 1'b1;
  logic [7:0] word = '0;
  logic [2:0] lines = '0;
  logic [7:0] status;
  logic [2:0] req;
  logic       sod;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  irq_mask_unit i_irq_mask_unit (
    .clk_i(clk), .rst_ni(rst_n), .ei_i(ei), .di_i(di), .mask_wr_i(mask_wr),
    .mask_word_i(word), .irq_ack_i(ack), .irq_line_i(lines), .sid_i(sid),
    .status_o(status), .req_o(req), .sod_o(sod)
  );

  task automatic chk(input int rq, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(1, "reset status", status, 8'h87);
    chk(1, "reset req", {5'b0, req}, 8'h00);
    chk(1, "reset sod", {7'b0, sod}, 8'h00);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {ei, di, mask_wr, ack} = TBL[i].ctl;
      word  = TBL[i].word;
      lines = TBL[i].lines;
      sid   = TBL[i].sid;
      @(posedge clk);
      #1;
      chk(int'(TBL[i].rq), $sformatf("vec %0d status", i), status, TBL[i].st);
      chk(int'(TBL[i].rq), $sformatf("vec %0d req", i), {5'b0, req}, {5'b0, TBL[i].req});
      chk(int'(TBL[i].rq), $sformatf("vec %0d sod", i), {7'b0, sod}, {7'b0, TBL[i].sod});
    end
    // R1 mid-run reset after sod set
    @(negedge clk);
    {ei, di, mask_wr, ack} = 4'b1010;
    word = 8'hC8; lines = 3'b100; sid = 1'b0;
    @(negedge clk);
    {ei, di, mask_wr, ack} = 4'b0000;
    rst_n = 1'b0;
    #1;
    chk(1, "mid reset status", status, 8'h47 & 8'h07);
    chk(1, "mid reset sod", {7'b0, sod}, 8'h00);
    chk(1, "mid reset req", {5'b0, req}, 8'h00);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (2000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule